// File: doc/BRIEF.md
# Table-Based Fixed-Point Square Root

This block takes an unsigned fixed-point operand and returns its square root in a wider-fraction fixed-point format. It does not use digit recurrence. It works in three steps. First it scales the operand by an even power of two, so that the reduced value lies in [1,4). Second it looks up two neighbouring roots in a constant table of 384 uniform bins across that interval, plus one extra entry for the upper end, and interpolates linearly between them. Third it shifts the interpolated root by half the reduction exponent.

The operand word is 32 bits wide with 16 fraction bits. Bit 31 acts as a sign bit, and a set sign bit is reported as an error. The result word is 32 bits wide with 8 integer bits and 24 fraction bits. The pipeline never stalls. It accepts one operand per cycle and returns each result a fixed number of cycles later. Typical users are track-fitting or radius calculations that need a root at every cycle.

Top module: `sqrt_lut_unit`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `out_valid` are low. `in_ready` rises on the first clock edge after reset is released and then stays high.
- R2: An operand is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` high exactly 4 cycles after the cycle in which it was presented. `out_valid` is never high for any other cycle, including operands offered during reset.
- R3: Operands presented in consecutive cycles produce results in consecutive cycles, in the same order.
- R4: Operand format: bit 31 is the sign, and bits 30:0 are the magnitude with 16 fraction bits, so 1.0 is 0x00010000. Result format: 8 integer and 24 fraction bits, so 1.0 is 0x01000000. An operand of 1.0 returns exactly 0x01000000.
- R5: For operands in [1,4), the result lies within 0.05% relative error of the true root, and `out_err` is low.
- R6: For operands from 4.0 up to the largest magnitude 0x7FFFFFFF, including both sides of each power-of-four boundary, the result lies within 0.05% relative error, and `out_err` is low.
- R7: For nonzero operands below 1.0, down to 0x00000001, the result lies within 0.05% relative error, and `out_err` is low.
- R8: An operand of zero returns 0 with `out_err` low.
- R9: An operand with bit 31 set returns 0 with `out_err` high.
- R10: An operand that is an exact power of four, 4^k for k from -8 to 7, returns exactly 2^k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Block can take an operand |
| in_data | input | 32 | Operand: sign bit 31, 15.16 magnitude |
| out_valid | output | 1 | Result present |
| out_root | output | 32 | Root, 8.24 fixed point |
| out_err | output | 1 | Operand had its sign bit set |

## Verification
The hardest case to reach is the last bin, where the interpolation must use the extra 2.0 entry. Reaching it takes a reduced value just under 4, which from the ports means an operand one LSB below a power-of-four boundary. The stimulus therefore sweeps every boundary 4^k together with its lower neighbour, and adds the largest magnitude and the smallest nonzero operand. These are followed by back-to-back random operands whose magnitudes are scaled down by random shifts, so that every reduction band is visited while the pipeline runs at full rate.

// File: rtl/sqrt_lut_pkg.sv
package sqrt_lut_pkg;
  localparam int DW        = 32;              // operand and result word
  localparam int IN_FRAC   = 16;              // operand fraction bits
  localparam int OUT_FRAC  = 24;              // result fraction bits
  localparam int BIN_SHIFT = 7;               // bins per unit of reduced value = 2**BIN_SHIFT
  localparam int NBINS     = 3 << BIN_SHIFT;  // bins over [1,4)
  localparam int MAN_FRAC  = DW - 2;          // reduced value held as 2.30
  localparam int WT_BITS   = MAN_FRAC - BIN_SHIFT;
  localparam int IDX_BITS  = $clog2(NBINS + 1);
  localparam int ROOT_BITS = OUT_FRAC + 2;    // root of reduced value, < 2.0
  localparam int SH_BITS   = $clog2(DW);
  localparam int SCL_BITS  = SH_BITS + 1;     // signed half-exponent

  // floor(sqrt(v)) by restoring bit pairs
  function automatic logic [31:0] isqrt64(input logic [63:0] v);
    logic [63:0] rem, res, bv;
    rem = v;
    res = '0;
    bv  = 64'h4000_0000_0000_0000;
    for (int i = 0; i < 32; i++) begin
      if (rem >= res + bv) begin
        rem = rem - (res + bv);
        res = (res >> 1) + bv;
      end else begin
        res = res >> 1;
      end
      bv = bv >> 2;
    end
    return res[31:0];
  endfunction
endpackage

// File: rtl/sqrt_range_reduce.sv
module sqrt_range_reduce
  import sqrt_lut_pkg::*;
(
  input  logic [DW-1:0]       x,
  output logic [IDX_BITS-1:0] idx,
  output logic [WT_BITS-1:0]  wt,
  output logic [SCL_BITS-1:0] scale,
  output logic                is_zero,
  output logic                is_neg
);
  logic [SH_BITS-1:0] lead, lead_even, sh;
  logic [DW-1:0]      man, off;

  always_comb begin
    lead = '0;
    for (int i = 0; i < DW - 1; i++) begin
      if (x[i]) lead = SH_BITS'(i);
    end
    lead_even = {lead[SH_BITS-1:1], 1'b0};
    sh        = SH_BITS'(DW - 2) - lead_even;
    man       = x << sh;
    off       = man - (DW'(1) << MAN_FRAC);
    is_neg    = x[DW-1];
    is_zero   = (x == '0);
    scale     = SCL_BITS'(lead_even >> 1) - SCL_BITS'(IN_FRAC / 2);
    if (is_neg || is_zero) begin
      idx = '0;
      wt  = '0;
    end else begin
      idx = off[WT_BITS +: IDX_BITS];
      wt  = off[WT_BITS-1:0];
    end
  end
endmodule

// File: rtl/sqrt_lut_rom.sv
module sqrt_lut_rom
  import sqrt_lut_pkg::*;
(
  input  logic [IDX_BITS-1:0]  idx,
  output logic [ROOT_BITS-1:0] lo,
  output logic [ROOT_BITS-1:0] hi
);
  logic [ROOT_BITS-1:0] tbl [0:NBINS];
  logic [IDX_BITS-1:0]  idx_nx;

  for (genvar k = 0; k <= NBINS; k++) begin : g_ent
    // entry k = sqrt(1 + k / 2**BIN_SHIFT) in OUT_FRAC fraction bits
    localparam logic [63:0] ARG =
      64'((1 << BIN_SHIFT) + k) << (2 * OUT_FRAC - BIN_SHIFT);
    localparam logic [31:0] ENT = isqrt64(ARG);
    assign tbl[k] = ENT[ROOT_BITS-1:0];
  end

  always_comb begin
    idx_nx = idx + IDX_BITS'(1);
    lo     = tbl[idx];
    hi     = tbl[idx_nx];
  end
endmodule

// File: rtl/sqrt_interp.sv
module sqrt_interp
  import sqrt_lut_pkg::*;
(
  input  logic [ROOT_BITS-1:0] lo,
  input  logic [ROOT_BITS-1:0] hi,
  input  logic [WT_BITS-1:0]   wt,
  output logic [ROOT_BITS-1:0] root
);
  localparam int PW = ROOT_BITS + WT_BITS;
  logic [ROOT_BITS-1:0] diff;
  logic [PW-1:0]        prod;

  always_comb begin
    diff = hi - lo;
    prod = PW'(diff) * PW'(wt);
    root = lo + ROOT_BITS'(prod >> WT_BITS);
  end
endmodule

// File: rtl/sqrt_lut_unit.sv
module sqrt_lut_unit
  import sqrt_lut_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_root,
  output logic          out_err
);
  // control state
  logic rdy_q, v1_q, v2_q, v3_q, v4_q;
  logic rdy_d, v1_d, v2_d, v3_d, v4_d, take;

  // stage 1: reduced operand
  logic [IDX_BITS-1:0]  r_idx, s1_idx;
  logic [WT_BITS-1:0]   r_wt, s1_wt, s2_wt;
  logic [SCL_BITS-1:0]  r_scale, s1_scale, s2_scale, s3_scale;
  logic                 r_zero, r_neg, s1_zero, s1_neg, s2_zero, s2_neg;
  // stage 2: table pair
  logic [ROOT_BITS-1:0] t_lo, t_hi, s2_lo, s2_hi;
  // stage 3: interpolated root
  logic [ROOT_BITS-1:0] i_root, s3_root;
  logic                 s3_kill, s3_neg;
  // stage 4: rescaled result
  logic [DW-1:0]        res_d, res_q, root_ext;
  logic [SCL_BITS-1:0]  scl_mag;
  logic                 err_q;

  sqrt_range_reduce u_red (
    .x(in_data), .idx(r_idx), .wt(r_wt), .scale(r_scale),
    .is_zero(r_zero), .is_neg(r_neg)
  );

  sqrt_lut_rom u_rom (.idx(s1_idx), .lo(t_lo), .hi(t_hi));

  sqrt_interp u_int (.lo(s2_lo), .hi(s2_hi), .wt(s2_wt), .root(i_root));

  always_comb begin
    take  = in_valid && rdy_q;
    rdy_d = 1'b1;
    v1_d  = take;
    v2_d  = v1_q;
    v3_d  = v2_q;
    v4_d  = v3_q;
    root_ext = DW'(s3_root);
    scl_mag  = s3_scale[SCL_BITS-1] ? (~s3_scale + SCL_BITS'(1)) : s3_scale;
    if (s3_kill)
      res_d = '0;
    else if (s3_scale[SCL_BITS-1])
      res_d = root_ext >> scl_mag;
    else
      res_d = root_ext << scl_mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      v1_q  <= 1'b0;
      v2_q  <= 1'b0;
      v3_q  <= 1'b0;
      v4_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      v1_q  <= v1_d;
      v2_q  <= v2_d;
      v3_q  <= v3_d;
      v4_q  <= v4_d;
    end
  end

  // payload registers, loaded only when the stage below holds a valid item
  always_ff @(posedge clk) begin
    if (take) begin
      s1_idx   <= r_idx;
      s1_wt    <= r_wt;
      s1_scale <= r_scale;
      s1_zero  <= r_zero;
      s1_neg   <= r_neg;
    end
    if (v1_q) begin
      s2_lo    <= t_lo;
      s2_hi    <= t_hi;
      s2_wt    <= s1_wt;
      s2_scale <= s1_scale;
      s2_zero  <= s1_zero;
      s2_neg   <= s1_neg;
    end
    if (v2_q) begin
      s3_root  <= i_root;
      s3_scale <= s2_scale;
      s3_kill  <= s2_zero || s2_neg;
      s3_neg   <= s2_neg;
    end
    if (v3_q) begin
      res_q    <= res_d;
      err_q    <= s3_neg;
    end
  end

  assign in_ready  = rdy_q;
  assign out_valid = v4_q;
  assign out_root  = res_q;
  assign out_err   = err_q;
endmodule

// File: rtl/sqrt_lut_unit_chk.sv
module sqrt_lut_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic        out_valid,
  input logic [31:0] out_root,
  input logic        out_err
);
  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R2
  no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready, 4));

  // R2
  no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready, 4) |-> out_valid);

  // R9
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_err == $past(in_data[31], 4)));

  // R9
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_root == 32'h0));

  // R8
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(in_data, 4) == 32'h0)) |-> (out_root == 32'h0 && !out_err));

  // R4
  unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ($past(in_data, 4) == 32'h0001_0000)) |-> (out_root == 32'h0100_0000));
endmodule

bind sqrt_lut_unit sqrt_lut_unit_chk u_chk (.*);

// File: tb/tb_sqrt_lut_unit.sv
module tb_sqrt_lut_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic [31:0] out_root;
  logic        out_err;

  always #2 clk = ~clk;

  sqrt_lut_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_root(out_root), .out_err(out_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  int ncyc  = 0;
  bit done  = 0;
  int          due_q [$];
  logic [31:0] x_q   [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, ncyc);
    end
  endtask

  function automatic string tag_of(input logic [31:0] x);
    if (x[31])                return "R9";
    if (x == 32'h0)           return "R8";
    if (x == 32'h0001_0000)   return "R4";
    if (x < 32'h0001_0000)    return "R7";
    if (x < 32'h0004_0000)    return "R5";
    return "R6";
  endfunction

  task automatic judge(input logic [31:0] x, input string tg);
    real ev, got, rel;
    int  pos;
    if (x[31]) begin
      chk(out_err && out_root == 0, "R9", "neg result", {out_err, out_root}, 64'h1_0000_0000);
    end else if (x == 0) begin
      chk(!out_err && out_root == 0, "R8", "zero result", {out_err, out_root}, 0);
    end else begin
      ev  = $sqrt(real'(x) / 65536.0);
      got = real'(out_root) / 16777216.0;
      rel = (got > ev) ? (got - ev) / ev : (ev - got) / ev;
      chk(!out_err && rel <= 5.0e-4, tg, "root", {out_err, out_root},
          longint'(ev * 16777216.0));
      if ($countones(x) == 1) begin
        pos = 0;
        for (int i = 0; i < 31; i++) if (x[i]) pos = i;
        if (pos % 2 == 0)
          chk(out_root == (32'h1 << (16 + pos / 2)), "R10", "exact power", out_root,
              longint'(32'h1 << (16 + pos / 2)));
      end
    end
  endtask

  task automatic compare();
    bit exp_v;
    exp_v = (due_q.size() > 0) && (due_q[0] == ncyc);
    if (exp_v || out_valid)
      chk(out_valid == exp_v, "R2", "out_valid", out_valid, exp_v);
    if (exp_v) begin
      if (out_valid) judge(x_q[0], tag_q[0]);
      void'(due_q.pop_front());
      void'(x_q.pop_front());
      void'(tag_q.pop_front());
    end
  endtask

  task automatic step(input bit v, input logic [31:0] d, input string tg = "");
    @(negedge clk);
    ncyc++;
    compare();
    in_valid = v;
    in_data  = d;
    if (v && in_ready) begin
      due_q.push_back(ncyc + 4);
      x_q.push_back(d);
      tag_q.push_back(tg == "" ? tag_of(d) : tg);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    // R1 / R2: operands offered during reset are dropped
    repeat (4) step(1'b1, 32'h0001_0000);
    chk(!in_ready && !out_valid, "R1", "reset state", {in_ready, out_valid}, 0);
    rst_n = 1'b1;
    step(1'b0, '0);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    repeat (6) step(1'b0, '0);

    // R4 unity, R8 zero, R9 negatives
    step(1'b1, 32'h0001_0000);
    step(1'b0, '0);
    step(1'b1, 32'h0);
    step(1'b1, 32'h8000_0000);
    step(1'b1, 32'hFFFF_FFFF);
    step(1'b1, 32'h8001_0000);
    step(1'b0, '0);

    // R10 / R6 / R7 / R5: every power-of-four edge and its lower neighbour
    for (int k = 0; k < 16; k++) begin
      step(1'b1, 32'h1 << (2 * k));
      step(1'b1, (32'h1 << (2 * k)) - 32'h1);
      step(1'b1, (32'h1 << (2 * k)) + 32'h1);
      step(1'b0, '0);
    end
    step(1'b1, 32'h7FFF_FFFF);            // R6 largest magnitude
    step(1'b1, 32'd2000 << 16);           // R6
    step(1'b1, 32'h0003_FFFF);            // R5 last bin
    step(1'b1, 32'h0002_0000);            // R5
    step(1'b1, 32'h0000_0003);            // R7

    // R3: back-to-back random operands across all bands
    for (int i = 0; i < 300; i++) begin
      x = ($urandom() & 32'h7FFF_FFFF) >> ($urandom() % 31);
      step(1'b1, x, "R3");
    end
    // gapped random operands, some with the sign bit
    for (int i = 0; i < 300; i++) begin
      x = ($urandom() & 32'h7FFF_FFFF) >> ($urandom() % 31);
      if ($urandom() % 16 == 0) x[31] = 1'b1;
      step(($urandom() % 3) != 0, x);
    end
    repeat (8) step(1'b0, '0);
    chk(due_q.size() == 0, "R2", "pending results", due_q.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule